// File: doc/BRIEF.md
# Supply Monitor Reset and Interrupt Controller

This block is the digital side of a supply monitor. Two comparators, supplied elsewhere, report whether the supply is below a reset level and whether it is below a higher warning level. The block resynchronises both indications and holds the core in reset while the supply is too low. Once the supply recovers, it keeps the reset asserted for a fixed stretch of oscillator cycles before letting go on its own.

It also keeps two sticky status bits. One records that a power-on reset took place. The other records that the supply dipped under the warning level. Only a software clear pulse removes either bit. The warning bit, gated by an enable, forms the power-fail interrupt request.

In stop mode a control bit chooses between two behaviours. With the bit clear, the reference and both comparators are switched off and their inputs are disregarded. With the bit set, the monitor stays on in a reduced-power state.

Top module: `supmon_ctrl`

## Requirements
- R1: While `rst` is high, `core_reset_o` is 1. With the reset comparator enabled, a 1 on `below_rst_i` sampled at a rising edge makes `core_reset_o` 1 after the third rising edge, counting that edge as the first. It then stays 1 while the input stays 1.
- R2: After `below_rst_i` is first sampled 0 following a below-threshold period or reset, `core_reset_o` is still 1 after rising edge RELEASE_CYCLES+1, counting that sample as edge 1. It is 0 after edge RELEASE_CYCLES+2. The default for RELEASE_CYCLES is 65,536. No software action is needed.
- R3: A 1 on `below_rst_i` sampled during the release count restarts the whole count. The R2 timing is then measured from the next 0 sample.
- R4: `por_flag_o` is 1 after `rst`. A one-cycle pulse on `sw_clr_por_i` clears it at the next edge. No other event sets it again, including a supply-low reset.
- R5: With the power-fail comparator enabled, a 1 on `below_warn_i` sampled at an edge sets `pf_flag_o` after the third edge, counting that edge as the first. Even a single-cycle pulse sets it. It stays 1 after the input returns to 0.
- R6: A pulse on `sw_clr_pf_i` clears `pf_flag_o` at the next edge. If a synchronised warning is present in the same cycle, the set wins and the flag stays 1.
- R7: `pf_irq_o` equals `pf_flag_o` AND `fail_irq_en_i`. With the enable at 0 the flag still sets, but the request stays 0. The request holds until the flag is cleared.
- R8: With `stop_i`=1 and `keep_ref_i`=0, `ref_en_o`, `rst_cmp_en_o`, `pf_cmp_en_o` and `low_pwr_o` are all 0. Both comparator inputs are then ignored: neither `pf_flag_o` nor `core_reset_o` can become 1.
- R9: With `stop_i`=1 and `keep_ref_i`=1, the three enables are 1 and `low_pwr_o` is 1. A warning still sets `pf_flag_o`.
- R10: With `stop_i`=0, the three enables are 1 and `low_pwr_o` is 0, whatever `keep_ref_i` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| below_rst_i | input | 1 | Reset comparator: 1 when the supply is below the reset level |
| below_warn_i | input | 1 | Warning comparator: 1 when the supply is below the warning level |
| stop_i | input | 1 | Core is in stop mode |
| keep_ref_i | input | 1 | Keep the monitor powered (reduced) during stop |
| fail_irq_en_i | input | 1 | Power-fail interrupt enable |
| sw_clr_por_i | input | 1 | Software pulse clearing the power-on flag |
| sw_clr_pf_i | input | 1 | Software pulse clearing the power-fail flag |
| core_reset_o | output | 1 | Internal reset to the core |
| por_flag_o | output | 1 | Sticky power-on reset flag |
| pf_flag_o | output | 1 | Sticky power-fail flag |
| pf_irq_o | output | 1 | Power-fail interrupt request |
| ref_en_o | output | 1 | Reference enable |
| rst_cmp_en_o | output | 1 | Reset comparator enable |
| pf_cmp_en_o | output | 1 | Power-fail comparator enable |
| low_pwr_o | output | 1 | Monitor runs in reduced-power mode |

## Verification
The bench pulses the reset input partway through a release count and checks that release comes a full count after the pulse. A counter that only held its value, or never cleared, would let go far too early.

The release edge is checked on both sides by one cycle. An off-by-one compare, or a miscounted synchroniser stage, shows up there.

A clear pulse is issued while a warning is still in flight. A design that let the clear win would drop a real power-fail event.

In stop mode with the monitor off, warning and reset pulses are applied. A design that did not gate the inputs would set the flag or reset the core.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

    // Synchronised comparator status; below_rst is the upper bit.
    typedef struct packed {
        logic below_rst;
        logic below_warn;
    } cmp_t;

    // Analog enables and power indication.
    typedef struct packed {
        logic ref_en;
        logic rst_cmp_en;
        logic pf_cmp_en;
        logic low_pwr;
    } gate_t;

    typedef enum logic {
        ST_HOLD = 1'b1,
        ST_RUN  = 1'b0
    } rst_state_e;

    // Safe state after reset: supply treated as below the reset level, no warning.
    localparam cmp_t CMP_RESET = '{below_rst: 1'b1, below_warn: 1'b0};

    function automatic gate_t gate_for(input logic stop, input logic keep);
        gate_t g;
        logic on;
        on           = !stop || keep;
        g.ref_en     = on;
        g.rst_cmp_en = on;
        g.pf_cmp_en  = on;
        g.low_pwr    = stop && keep;
        return g;
    endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
    parameter int               WIDTH     = 2,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RESET_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/supmon_rst_stretch.sv
module supmon_rst_stretch
    import supmon_pkg::*;
#(
    parameter int RELEASE_CYCLES = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic below,
    output logic core_reset
);
    localparam int            CW   = (RELEASE_CYCLES > 1) ? $clog2(RELEASE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RELEASE_CYCLES - 1);

    rst_state_e    state;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else if (below) begin
            state <= ST_HOLD;
            cnt   <= '0;
        end else if (state == ST_HOLD) begin
            if (cnt == LAST) begin
                state <= ST_RUN;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign core_reset = (state == ST_HOLD);

    assert_low_supply_holds_R1: assert property (@(posedge clk) disable iff (rst)
        below |=> core_reset);

    assert_release_clean_R2: assert property (@(posedge clk) disable iff (rst)
        $fell(core_reset) |-> !$past(below));

    assert_restart_zero_R3: assert property (@(posedge clk) disable iff (rst)
        below |=> (cnt == '0));
endmodule

// File: rtl/supmon_flags.sv
module supmon_flags (
    input  logic clk,
    input  logic rst,
    input  logic warn,
    input  logic irq_en,
    input  logic clr_por,
    input  logic clr_pf,
    output logic por_flag,
    output logic pf_flag,
    output logic pf_irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            por_flag <= 1'b1;
            pf_flag  <= 1'b0;
        end else begin
            if (clr_por) por_flag <= 1'b0;
            if (warn)        pf_flag <= 1'b1;
            else if (clr_pf) pf_flag <= 1'b0;
        end
    end

    assign pf_irq = pf_flag && irq_en;

    assert_por_never_sets_R4: assert property (@(posedge clk) disable iff (rst)
        !por_flag |=> !por_flag);

    assert_pf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (pf_flag && !clr_pf) |=> pf_flag);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (warn && clr_pf) |=> pf_flag);

    assert_irq_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (pf_irq && !clr_pf && irq_en) |=> (pf_irq || !irq_en));
endmodule

// File: rtl/supmon_ctrl.sv
module supmon_ctrl
    import supmon_pkg::*;
#(
    parameter int RELEASE_CYCLES = 65536,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic below_rst_i,
    input  logic below_warn_i,
    input  logic stop_i,
    input  logic keep_ref_i,
    input  logic fail_irq_en_i,
    input  logic sw_clr_por_i,
    input  logic sw_clr_pf_i,
    output logic core_reset_o,
    output logic por_flag_o,
    output logic pf_flag_o,
    output logic pf_irq_o,
    output logic ref_en_o,
    output logic rst_cmp_en_o,
    output logic pf_cmp_en_o,
    output logic low_pwr_o
);
    localparam int CMP_W = $bits(cmp_t);

    cmp_t  raw, synced;
    gate_t gate;
    logic  rst_eff, warn_eff;

    assign raw.below_rst  = below_rst_i;
    assign raw.below_warn = below_warn_i;

    supmon_sync #(
        .WIDTH    (CMP_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(CMP_RESET)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  (raw),
        .q  (synced)
    );

    assign gate     = gate_for(stop_i, keep_ref_i);
    assign rst_eff  = synced.below_rst  && gate.rst_cmp_en;
    assign warn_eff = synced.below_warn && gate.pf_cmp_en;

    supmon_rst_stretch #(
        .RELEASE_CYCLES(RELEASE_CYCLES)
    ) u_stretch (
        .clk       (clk),
        .rst       (rst),
        .below     (rst_eff),
        .core_reset(core_reset_o)
    );

    supmon_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .warn    (warn_eff),
        .irq_en  (fail_irq_en_i),
        .clr_por (sw_clr_por_i),
        .clr_pf  (sw_clr_pf_i),
        .por_flag(por_flag_o),
        .pf_flag (pf_flag_o),
        .pf_irq  (pf_irq_o)
    );

    assign ref_en_o     = gate.ref_en;
    assign rst_cmp_en_o = gate.rst_cmp_en;
    assign pf_cmp_en_o  = gate.pf_cmp_en;
    assign low_pwr_o    = gate.low_pwr;

    assert_off_ignores_warn_R8: assert property (@(posedge clk) disable iff (rst)
        (!pf_flag_o && !pf_cmp_en_o) |=> !pf_flag_o);

    assert_off_ignores_rst_R8: assert property (@(posedge clk) disable iff (rst)
        (!core_reset_o && !rst_cmp_en_o) |=> !core_reset_o);
endmodule

// File: tb/test_supmon_ctrl.sv
module test_supmon_ctrl;
    localparam int REL = 65536;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic below_rst_i = 1'b0, below_warn_i = 1'b0, stop_i = 1'b0, keep_ref_i = 1'b0;
    logic fail_irq_en_i = 1'b0, sw_clr_por_i = 1'b0, sw_clr_pf_i = 1'b0;
    logic core_reset_o, por_flag_o, pf_flag_o, pf_irq_o;
    logic ref_en_o, rst_cmp_en_o, pf_cmp_en_o, low_pwr_o;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    supmon_ctrl i_supmon_ctrl (
        .clk(clk), .rst(rst),
        .below_rst_i(below_rst_i), .below_warn_i(below_warn_i),
        .stop_i(stop_i), .keep_ref_i(keep_ref_i), .fail_irq_en_i(fail_irq_en_i),
        .sw_clr_por_i(sw_clr_por_i), .sw_clr_pf_i(sw_clr_pf_i),
        .core_reset_o(core_reset_o), .por_flag_o(por_flag_o),
        .pf_flag_o(pf_flag_o), .pf_irq_o(pf_irq_o),
        .ref_en_o(ref_en_o), .rst_cmp_en_o(rst_cmp_en_o),
        .pf_cmp_en_o(pf_cmp_en_o), .low_pwr_o(low_pwr_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Advance n rising edges and land on the following falling edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        step(3);
        chk("R1 reset holds core", core_reset_o, 1'b1);
        chk("R4 por set by reset", por_flag_o, 1'b1);
        chk("R5 pf clear at reset", pf_flag_o, 1'b0);
        chk("R7 irq clear at reset", pf_irq_o, 1'b0);
        rst = 1'b0;
    endtask

    task automatic t_restart;
        step(1000);
        chk("R2 still counting", core_reset_o, 1'b1);
        below_rst_i = 1'b1;
        step(1);
        below_rst_i = 1'b0;
        step(REL + 1);
        chk("R3 count restarted", core_reset_o, 1'b1);
        step(1);
        chk("R2 release after full count", core_reset_o, 1'b0);
    endtask

    task automatic t_por_clear;
        sw_clr_por_i = 1'b1;
        step(1);
        sw_clr_por_i = 1'b0;
        chk("R4 por cleared", por_flag_o, 1'b0);
    endtask

    task automatic t_brownout;
        below_rst_i = 1'b1;
        step(2);
        chk("R1 not yet asserted", core_reset_o, 1'b0);
        step(1);
        chk("R1 asserted third edge", core_reset_o, 1'b1);
        step(5);
        chk("R1 held while low", core_reset_o, 1'b1);
        below_rst_i = 1'b0;
        step(REL + 1);
        chk("R2 held edge REL+1", core_reset_o, 1'b1);
        step(1);
        chk("R2 released edge REL+2", core_reset_o, 1'b0);
        chk("R4 por not set by brownout", por_flag_o, 1'b0);
    endtask

    task automatic t_pf_set_clear;
        fail_irq_en_i = 1'b1;
        below_warn_i = 1'b1;
        step(1);
        below_warn_i = 1'b0;
        step(1);
        chk("R5 pf not yet set", pf_flag_o, 1'b0);
        step(1);
        chk("R5 pf set third edge", pf_flag_o, 1'b1);
        chk("R7 irq raised", pf_irq_o, 1'b1);
        step(5);
        chk("R5 pf sticky", pf_flag_o, 1'b1);
        chk("R7 irq held", pf_irq_o, 1'b1);
        sw_clr_pf_i = 1'b1;
        step(1);
        sw_clr_pf_i = 1'b0;
        chk("R6 pf cleared", pf_flag_o, 1'b0);
        chk("R7 irq dropped", pf_irq_o, 1'b0);
    endtask

    task automatic t_set_wins;
        below_warn_i = 1'b1;
        step(3);
        chk("R6 warn set flag", pf_flag_o, 1'b1);
        sw_clr_pf_i = 1'b1;
        step(1);
        sw_clr_pf_i = 1'b0;
        chk("R6 set wins over clear", pf_flag_o, 1'b1);
        below_warn_i = 1'b0;
        step(3);
        sw_clr_pf_i = 1'b1;
        step(1);
        sw_clr_pf_i = 1'b0;
        chk("R6 clear after drain", pf_flag_o, 1'b0);
    endtask

    task automatic t_mask;
        fail_irq_en_i = 1'b0;
        below_warn_i = 1'b1;
        step(1);
        below_warn_i = 1'b0;
        step(3);
        chk("R7 flag set while masked", pf_flag_o, 1'b1);
        chk("R7 irq masked", pf_irq_o, 1'b0);
        fail_irq_en_i = 1'b1;
        #1;
        chk("R7 irq follows enable", pf_irq_o, 1'b1);
        sw_clr_pf_i = 1'b1;
        step(1);
        sw_clr_pf_i = 1'b0;
        chk("R7 irq gone after clear", pf_irq_o, 1'b0);
    endtask

    task automatic t_stop_off;
        keep_ref_i = 1'b1;
        #1;
        chk("R10 ref on when running", ref_en_o, 1'b1);
        chk("R10 no low power when running", low_pwr_o, 1'b0);
        stop_i = 1'b1;
        keep_ref_i = 1'b0;
        #1;
        chk("R8 ref off", ref_en_o, 1'b0);
        chk("R8 rst cmp off", rst_cmp_en_o, 1'b0);
        chk("R8 pf cmp off", pf_cmp_en_o, 1'b0);
        chk("R8 low power off", low_pwr_o, 1'b0);
        below_warn_i = 1'b1;
        below_rst_i = 1'b1;
        step(1);
        below_warn_i = 1'b0;
        below_rst_i = 1'b0;
        step(5);
        chk("R8 warn ignored", pf_flag_o, 1'b0);
        chk("R8 reset input ignored", core_reset_o, 1'b0);
        stop_i = 1'b0;
        #1;
        chk("R10 enables back", pf_cmp_en_o & rst_cmp_en_o & ref_en_o, 1'b1);
        chk("R10 low power clear", low_pwr_o, 1'b0);
    endtask

    task automatic t_stop_keep;
        stop_i = 1'b1;
        keep_ref_i = 1'b1;
        #1;
        chk("R9 enables kept", pf_cmp_en_o & rst_cmp_en_o & ref_en_o, 1'b1);
        chk("R9 low power on", low_pwr_o, 1'b1);
        below_warn_i = 1'b1;
        step(1);
        below_warn_i = 1'b0;
        step(3);
        chk("R9 warn still sets flag", pf_flag_o, 1'b1);
        stop_i = 1'b0;
        keep_ref_i = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        t_reset;
        t_restart;
        t_por_clear;
        t_brownout;
        t_pf_set_clear;
        t_set_wins;
        t_mask;
        t_stop_off;
        t_stop_keep;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000 && !done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule